// File: doc/BRIEF.md
# Reset and calibration sequencer

This block merges three reset sources into one chip-wide reset: a supply-good flag, an oscillator-stable flag and an active-low external reset pin. The pin counts only after its low level has been qualified by a minimum width. Once every source is quiet, the block runs a fixed calibration interval. After that interval it starts the shared transmit clock. During reset and calibration the transmit clock is held low.

The block runs from a free-running reference clock. The supply and oscillator flags are digital status inputs and are treated as synchronous to that clock. The external pin crosses two synchronizing flops before its low time is counted. Every duration is a cycle-count parameter. With a 100 MHz reference, the defaults give 500 ns pin qualification, a 36 ms calibration window and a 10 MHz transmit clock. A bench can override them with small values.

Top module: `rst_cal_seq`

## Requirements
- R1: A low level on `ext_rst_ni` that is sampled on fewer than `EXT_MIN_LO` consecutive clock edges never raises `chip_rst_o` or `cal_busy_o`.
- R2: A low level on `ext_rst_ni` that is sampled on `w >= EXT_MIN_LO` consecutive edges raises `chip_rst_o` first `EXT_MIN_LO+3` cycles after the first low edge. It then holds it for exactly `w-EXT_MIN_LO+1` cycles.
- R3: `pwr_good_i` low at a clock edge sets `chip_rst_o` high after that edge, for as many cycles as the flag was sampled low.
- R4: `chip_rst_o` is released only after an edge at which both `pwr_good_i` and `osc_stable_i` are high and no qualified pin reset is pending.
- R5: Once reset is released, `cal_busy_o` is high for exactly `CAL_CYCLES` cycles and then falls with `chip_rst_o` low.
- R6: `tx_clk_o` is low in every cycle in which `chip_rst_o` or `cal_busy_o` is high.
- R7: After calibration, `tx_clk_o` is low for the first `TX_HALF` cycles and then toggles every `TX_HALF` reference cycles (period `2*TX_HALF`).
- R8: Any reset condition during calibration returns the block to reset. The next calibration then runs its full `CAL_CYCLES` length.
- R9: While `rst_ni` is low, `chip_rst_o`=1 and `cal_busy_o`=0. `chip_rst_o` and `cal_busy_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous flop initialisation, active low |
| pwr_good_i | input | 1 | Supply above power-good threshold |
| osc_stable_i | input | 1 | Crystal oscillator reported stable |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| chip_rst_o | output | 1 | Chip-wide internal reset |
| cal_busy_o | output | 1 | Calibration interval in progress |
| tx_clk_o | output | 1 | Gated transmit clock, low until calibration ends |

## Verification
Each result falls due a fixed number of cycles after its stimulus:
- A supply or oscillator drop shows on `chip_rst_o` one cycle after the edge that samples it.
- A qualified pin pulse shows `EXT_MIN_LO+3` cycles after its first low edge.
- Calibration lasts exactly `CAL_CYCLES` cycles.
- The first rising edge of the transmit clock comes `TX_HALF` cycles into the run state.

The bench indexes every sample by the number of edges since the stimulus was applied. It drives 2 ns after each edge and samples at the same point. The checks compare the first-assertion cycle, the count of reset and calibration cycles, and the clock level against values computed from these numbers. Pulse widths are swept from 1 to `EXT_MIN_LO+2` for the pin, and over several widths for the supply and oscillator flags.

// File: rtl/rst_cal_pkg.sv
package rst_cal_pkg;
  typedef enum logic [1:0] {
    SEQ_RST = 2'd0,
    SEQ_CAL = 2'd1,
    SEQ_RUN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rst_pin_filt.sv
module rst_pin_filt #(
  parameter int MIN_LO = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic hit_o
);
  localparam int CW = $clog2(MIN_LO + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LO);

  logic [1:0]    sync_q;
  logic [CW-1:0] lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], pin_ni};
  end

  // consecutive low cycles after sync, saturating at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lo_cnt_q <= '0;
    else if (sync_q[1])       lo_cnt_q <= '0;
    else if (lo_cnt_q != LIM) lo_cnt_q <= lo_cnt_q + 1'b1;
  end

  assign hit_o = (lo_cnt_q == LIM);

  AST_HIT_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> !$past(sync_q[1])); // R2

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import rst_cal_pkg::*;
#(
  parameter int CAL_CYCLES = 3600000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  output seq_state_e state_o
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (req_i) begin
      state_d = SEQ_RST;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SEQ_RST: begin
          state_d = SEQ_CAL;
          cnt_d   = '0;
        end
        SEQ_CAL: begin
          if (cnt_q == LAST) state_d = SEQ_RUN;
          else               cnt_d   = cnt_q + 1'b1;
        end
        SEQ_RUN: state_d = SEQ_RUN;
        default: state_d = SEQ_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_RST;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  AST_REQ_FORCES_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> state_q == SEQ_RST); // R8
  AST_CAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_CAL && cnt_q != LAST && !req_i) |=> state_q == SEQ_CAL); // R5
  AST_CAL_FROM_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RUN) |-> ($past(state_q) != SEQ_RST)); // R5

endmodule

// File: rtl/tx_clk_div.sv
module tx_clk_div #(
  parameter int TX_HALF = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tx_clk_o
);
  localparam int DW = (TX_HALF > 1) ? $clog2(TX_HALF) : 1;
  localparam logic [DW-1:0] LAST = DW'(TX_HALF - 1);

  logic [DW-1:0] div_q;
  logic          clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      div_q <= '0;
      clk_q <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // gate so the output drops in the same cycle run falls
  assign tx_clk_o = clk_q & run_i;

  AST_TX_HALF_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && div_q != LAST) |=> (!run_i || $stable(clk_q))); // R7

endmodule

// File: rtl/rst_cal_seq.sv
module rst_cal_seq
  import rst_cal_pkg::*;
#(
  parameter int EXT_MIN_LO = 50,
  parameter int CAL_CYCLES = 3600000,
  parameter int TX_HALF    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic osc_stable_i,
  input  logic ext_rst_ni,
  output logic chip_rst_o,
  output logic cal_busy_o,
  output logic tx_clk_o
);
  logic       ext_hit;
  logic       rst_req;
  seq_state_e state;

  rst_pin_filt #(.MIN_LO(EXT_MIN_LO)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_ni(ext_rst_ni),
    .hit_o (ext_hit)
  );

  assign rst_req = !pwr_good_i || !osc_stable_i || ext_hit;

  seq_fsm #(.CAL_CYCLES(CAL_CYCLES)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rst_req),
    .state_o(state)
  );

  tx_clk_div #(.TX_HALF(TX_HALF)) u_txdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state == SEQ_RUN),
    .tx_clk_o(tx_clk_o)
  );

  assign chip_rst_o = (state == SEQ_RST);
  assign cal_busy_o = (state == SEQ_CAL);

  AST_PWR_LOSS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> chip_rst_o); // R3
  AST_OSC_BLOCKS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rst_o && !osc_stable_i) |=> chip_rst_o); // R4
  AST_TX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_rst_o || cal_busy_o) |-> !tx_clk_o); // R6
  AST_RST_CAL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chip_rst_o, cal_busy_o})); // R9

endmodule

// File: tb/sim_rst_cal_seq.sv
module sim_rst_cal_seq;
  localparam int MIN_LO = 4;
  localparam int CAL    = 20;
  localparam int HALF   = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good_i = 1'b1;
  logic osc_stable_i = 1'b1;
  logic ext_rst_ni = 1'b1;
  logic chip_rst_o, cal_busy_o, tx_clk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rst_cal_seq #(.EXT_MIN_LO(MIN_LO), .CAL_CYCLES(CAL), .TX_HALF(HALF)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .osc_stable_i(osc_stable_i), .ext_rst_ni(ext_rst_ni),
    .chip_rst_o(chip_rst_o), .cal_busy_o(cal_busy_o), .tx_clk_o(tx_clk_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  // from a reset sample, count calibration cycles up to the first run sample
  task automatic run_cal(input string req);
    int n = 0;
    int guard = 0;
    int txbad = 0;
    while ((chip_rst_o || cal_busy_o) && guard < CAL + 100) begin
      if (cal_busy_o) n++;
      if (tx_clk_o) txbad++;
      step();
      guard++;
    end
    chk(n == CAL, req, "calibration cycles", n, CAL);
    chk(txbad == 0, "R6", "tx clock high during reset/cal", txbad, 0);
  endtask

  // starts at the first sample of the run state
  task automatic check_clk();
    for (int k = 0; k < 4 * HALF; k++) begin
      chk(tx_clk_o == ((k / HALF) % 2), "R7", $sformatf("tx clock at run cycle %0d", k),
          tx_clk_o, (k / HALF) % 2);
      step();
    end
  endtask

  // kind 0: external pin, 1: supply flag, 2: oscillator flag
  task automatic pulse(input int kind, input int w);
    int rst_n = 0;
    int cal_n = 0;
    int first = -1;
    int txbad = 0;
    int exp_rst, exp_first;
    string req;
    case (kind)
      0: ext_rst_ni = 1'b0;
      1: pwr_good_i = 1'b0;
      default: osc_stable_i = 1'b0;
    endcase
    for (int t = 1; t < 4000; t++) begin
      step();
      if (chip_rst_o) begin
        rst_n++;
        if (first < 0) first = t;
      end
      if (cal_busy_o) cal_n++;
      if ((chip_rst_o || cal_busy_o) && tx_clk_o) txbad++;
      if (chip_rst_o && cal_busy_o) chk(1'b0, "R9", "reset and cal together", 1, 0);
      if (t == w) begin
        ext_rst_ni = 1'b1;
        pwr_good_i = 1'b1;
        osc_stable_i = 1'b1;
      end
      if (t >= w + 8 && !chip_rst_o && !cal_busy_o) break;
    end
    if (kind == 0) begin
      exp_rst   = (w >= MIN_LO) ? w - MIN_LO + 1 : 0;
      exp_first = MIN_LO + 3;
      req       = (w >= MIN_LO) ? "R2" : "R1";
    end else begin
      exp_rst   = w;
      exp_first = 1;
      req       = (kind == 1) ? "R3" : "R4";
    end
    chk(rst_n == exp_rst, req, $sformatf("reset cycles kind %0d width %0d", kind, w), rst_n, exp_rst);
    if (exp_rst > 0)
      chk(first == exp_first, req, $sformatf("reset latency kind %0d width %0d", kind, w),
          first, exp_first);
    chk(cal_n == ((exp_rst > 0) ? CAL : 0), "R5", $sformatf("cal cycles kind %0d width %0d", kind, w),
        cal_n, (exp_rst > 0) ? CAL : 0);
    chk(txbad == 0, "R6", "tx clock high during reset/cal", txbad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    report();
  end

  initial begin
    osc_stable_i = 1'b0;
    repeat (3) step();
    // R9: state while held in reset
    chk(chip_rst_o == 1'b1, "R9", "chip_rst in reset", chip_rst_o, 1);
    chk(cal_busy_o == 1'b0, "R9", "cal_busy in reset", cal_busy_o, 0);
    chk(tx_clk_o == 1'b0, "R6", "tx clock in reset", tx_clk_o, 0);
    rst_ni = 1'b1;
    // R4: oscillator not yet stable keeps reset
    for (int i = 0; i < 10; i++) begin
      step();
      chk(chip_rst_o == 1'b1 && cal_busy_o == 1'b0, "R4", "held with osc unstable",
          {chip_rst_o, cal_busy_o}, 2);
    end
    osc_stable_i = 1'b1;
    run_cal("R5");
    check_clk();

    // R1/R2 sweep of pin widths
    for (int w = 1; w <= MIN_LO + 2; w++) pulse(0, w);
    // R3 supply loss, then clock restart check
    for (int w = 1; w <= 3; w++) pulse(1, w);
    check_clk();
    // R4 oscillator loss
    for (int w = 1; w <= 3; w++) pulse(2, w);
    check_clk();

    // R8: reset request mid-calibration restarts the full interval
    pwr_good_i = 1'b0;
    step();
    step();
    pwr_good_i = 1'b1;
    repeat (8) step();
    chk(cal_busy_o == 1'b1, "R8", "in calibration before abort", cal_busy_o, 1);
    osc_stable_i = 1'b0;
    step();
    chk(chip_rst_o == 1'b1, "R8", "abort to reset", chip_rst_o, 1);
    osc_stable_i = 1'b1;
    run_cal("R8");
    check_clk();

    // R8: qualified pin reset during calibration
    pwr_good_i = 1'b0;
    step();
    pwr_good_i = 1'b1;
    repeat (5) step();
    ext_rst_ni = 1'b0;
    repeat (MIN_LO + 3) step();
    chk(chip_rst_o == 1'b1, "R8", "pin abort to reset", chip_rst_o, 1);
    ext_rst_ni = 1'b1;
    repeat (4) begin
      if (cal_busy_o) break;
      step();
    end
    chk(chip_rst_o == 1'b0 && cal_busy_o == 1'b1, "R8", "cal restarted after pin release",
        {chip_rst_o, cal_busy_o}, 1);
    report();
  end
endmodule